// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block sends a stereo pair of audio samples, left then right, over one serial data line. A bit clock and a word clock go with the data. All logic runs on one master clock at 256 times the sample rate. In master mode the port makes both serial clocks from that master clock. In slave mode it follows a bit clock and a word clock that arrive from outside. Those external clocks are assumed to be derived from the same master clock, so a single register stage is enough to sample them.

Each channel has a fixed field of bit slots: 32 slots normally, or 16 when the short-field pin is set. Samples are two's complement and sent MSB first. Static pins pick where the word sits in its field: flush against the end of the field (right-justified), one slot after the word-clock edge (I2S), or at a slot number given on a pin. With the 16-slot field the word is cut down to its most significant bits. Every slot that carries no word bit is sent as zero. The data line changes only on a falling bit-clock edge, so a receiver can sample on the rising edge.

Both input words are captured together at the start of each left field. The inputs may therefore change at any time without tearing the pair being sent.

Top module: `audio_serial_tx`

## Requirements
- R1: While reset is held, and on the first cycle after it, `sdata`, `bclk_out` and `wclk_out` are all low.
- R2: In master mode with the 32-slot field, `bclk_out` has a period of 4 master clocks. With the 16-slot field the period is 8 master clocks. In both cases `wclk_out` has a period of 256 master clocks and stays low for 128 of them.
- R3: `sdata` and the word clock change only when the bit clock goes from high to low.
- R4: With `fmt` = 2'b00 (right-justified) the last word bit sits in the last slot of the field. For an 18-bit word in a 32-slot field this puts the MSB in slot 14 and sends slots 0 to 13 as zero. Slot 0 is the first bit period after the word-clock edge.
- R5: With `fmt` = 2'b01 (I2S) the MSB sits in slot 1 and slot 0 is zero. Slots after the LSB are zero.
- R6: With `fmt[1]` = 1 (offset mode) the MSB sits in slot `ofs`. Word bits that would fall past the end of the field are dropped.
- R7: With `short_field` = 1 each field has 16 slots and the word is cut to its 16 most significant bits. Right-justified mode then starts the MSB at slot 0, and I2S mode also drops bit 2 of an 18-bit word.
- R8: Both words are captured at the first slot of each left field. A change on `left_word` or `right_word` during a frame shows up only from the next frame.
- R9: With `master_en` = 0 the port takes its timing from `bclk_in` and `wclk_in`. Slot 0 starts at the first falling edge of `bclk_in` on which `wclk_in` has a new level. `bclk_out` and `wclk_out` are held low.
- R10: The left word is sent while the word clock is low and the right word while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | 1: generate the serial clocks; 0: follow the external ones |
| short_field | input | 1 | 1: 16-slot field per channel; 0: 32-slot field |
| fmt | input | 2 | Word placement: 00 right-justified, 01 I2S, 1x offset |
| ofs | input | 5 | Slot of the MSB in offset mode |
| left_word | input | 18 | Left sample, two's complement |
| right_word | input | 18 | Right sample, two's complement |
| bclk_in | input | 1 | External bit clock (slave mode) |
| wclk_in | input | 1 | External word clock (slave mode), low marks left |
| bclk_out | output | 1 | Generated bit clock (master mode), otherwise low |
| wclk_out | output | 1 | Generated word clock (master mode), otherwise low |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The bench checks each placement mode against slot maps it builds itself. It covers these corner cases:
- I2S: the one-slot delay after the word-clock edge. A design that left out the delay would shift every word one slot early.
- Offset mode: an offset large enough that the word runs past the end of its field. A design that wrapped the overflow instead of dropping it would leak bits into the other channel.
- 16-slot field: truncation in both right-justified and I2S modes. A design that kept the LSBs instead of the MSBs would send the wrong half of the sample.
- Mid-frame update: both input words change partway through a frame. A port without the frame-start capture would send a torn word.
- Slave mode: the external word-clock edge must restart the slot count. A design that counted freely would lose alignment with the external frame.

// File: rtl/ast_pkg.sv
// Shared encodings for the stereo audio serial output port.
// Assumes: fmt is a static pin selection; codes 2'b10 and 2'b11 both mean offset.
package ast_pkg;

    typedef enum logic [1:0] {
        PLACE_RJUST  = 2'b00,
        PLACE_I2S    = 2'b01,
        PLACE_OFFSET = 2'b10,
        PLACE_OFFALT = 2'b11
    } place_e;

endpackage

// File: rtl/ast_master_timing.sv
// Master-mode timing: divides the master clock into bit and word clocks.
// Every field change and every slot advance happen on a falling bit-clock edge.
// It emits a strobe one master cycle before each falling edge, together with the
// slot and channel that start on that edge.
// Assumes: MCLK_PER_FS is a multiple of 2*SHORT_W and of 2*FIELD_W.
module ast_master_timing #(
    parameter int MCLK_PER_FS = 256,
    parameter int FIELD_W     = 32,
    parameter int SHORT_W     = 16,
    parameter int SLOT_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              short_field,
    output logic              bclk,
    output logic              wclk,
    output logic              strobe,
    output logic              nxt_chan,
    output logic [SLOT_W-1:0] nxt_slot
);
    localparam int DIV_L = MCLK_PER_FS / (2 * FIELD_W);
    localparam int DIV_S = MCLK_PER_FS / (2 * SHORT_W);
    localparam int PH_W  = (DIV_S > 2) ? $clog2(DIV_S) : 1;
    localparam logic [PH_W-1:0]   PH_LIM_L   = PH_W'(DIV_L - 1);
    localparam logic [PH_W-1:0]   PH_LIM_S   = PH_W'(DIV_S - 1);
    localparam logic [PH_W-1:0]   HALF_L     = PH_W'(DIV_L / 2);
    localparam logic [PH_W-1:0]   HALF_S     = PH_W'(DIV_S / 2);
    localparam logic [SLOT_W-1:0] SLOT_LIM_L = SLOT_W'(FIELD_W - 1);
    localparam logic [SLOT_W-1:0] SLOT_LIM_S = SLOT_W'(SHORT_W - 1);

    logic [PH_W-1:0]   ph;
    logic [SLOT_W-1:0] slot;
    logic              chan;
    logic [PH_W-1:0]   ph_lim;
    logic [PH_W-1:0]   half;
    logic [SLOT_W-1:0] slot_lim;

    // Pick the divider limits for the selected field length.
    always_comb begin
        ph_lim   = short_field ? PH_LIM_S   : PH_LIM_L;
        half     = short_field ? HALF_S     : HALF_L;
        slot_lim = short_field ? SLOT_LIM_S : SLOT_LIM_L;
    end

    // Work out the slot and channel that begin at the next falling edge.
    always_comb begin
        strobe   = (ph >= ph_lim);
        nxt_slot = (slot >= slot_lim) ? '0 : slot + 1'b1;
        nxt_chan = (slot >= slot_lim) ? ~chan : chan;
    end

    // Advance the phase counter, and the slot and channel on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph   <= '0;
            slot <= '0;
            chan <= 1'b0;
        end else if (strobe) begin
            ph   <= '0;
            slot <= nxt_slot;
            chan <= nxt_chan;
        end else begin
            ph   <= ph + 1'b1;
        end
    end

    assign bclk = (ph >= half);
    assign wclk = chan;

    // The word clock may only move together with a falling bit clock.
    assert_ws_on_bclk_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wclk != $past(wclk)) |-> (!bclk && $past(bclk)));

endmodule

// File: rtl/ast_slave_timing.sv
// Slave-mode timing: samples the external bit and word clocks on the master
// clock and finds the falling bit-clock edges.
// The slot count restarts at zero on the first falling edge that sees a new
// word-clock level, and stops at its top value when no word-clock edge comes.
// Assumes: the external clocks come from the master clock, so one sampling
// register is enough.
module ast_slave_timing #(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_in,
    input  logic              wclk_in,
    output logic              strobe,
    output logic              nxt_chan,
    output logic [SLOT_W-1:0] nxt_slot
);
    localparam logic [SLOT_W-1:0] SLOT_TOP = '1;

    logic              bclk_s;
    logic              bclk_d;
    logic              wclk_s;
    logic              wclk_last;
    logic [SLOT_W-1:0] slot;

    // Sample the external clocks and keep one bit-clock value of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_s <= 1'b0;
            bclk_d <= 1'b0;
            wclk_s <= 1'b0;
        end else begin
            bclk_s <= bclk_in;
            bclk_d <= bclk_s;
            wclk_s <= wclk_in;
        end
    end

    // Find falling edges; a new word-clock level restarts the count, otherwise it saturates.
    always_comb begin
        strobe   = bclk_d && !bclk_s;
        nxt_chan = wclk_s;
        if (wclk_s != wclk_last)
            nxt_slot = '0;
        else if (slot == SLOT_TOP)
            nxt_slot = SLOT_TOP;
        else
            nxt_slot = slot + 1'b1;
    end

    // Store the slot and the word-clock level seen at each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot      <= SLOT_TOP;
            wclk_last <= 1'b0;
        end else if (strobe) begin
            slot      <= nxt_slot;
            wclk_last <= wclk_s;
        end
    end

    // A slot count that restarts must come from a falling edge on which the word clock moved.
    assert_slot_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == '0 && $past(slot) != '0) |-> ($past(strobe) && $past(wclk_s) != $past(wclk_last)));

endmodule

// File: rtl/ast_formatter.sv
// Places the left or right word into its field and drives the serial data bit.
// On each strobe it decides whether the next slot holds a word bit and which one.
// It captures both input words at the first slot of the left field.
// Assumes: strobe comes one master cycle before the falling bit-clock edge.
module ast_formatter #(
    parameter int WORD_W  = 18,
    parameter int FIELD_W = 32,
    parameter int SHORT_W = 16,
    parameter int SLOT_W  = 6,
    parameter int OFS_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              chan,
    input  logic [SLOT_W-1:0] slot,
    input  logic [1:0]        fmt,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              short_field,
    input  logic [WORD_W-1:0] left_word,
    input  logic [WORD_W-1:0] right_word,
    output logic              sdata
);
    import ast_pkg::*;

    localparam int LEN_L = (WORD_W < FIELD_W) ? WORD_W : FIELD_W;
    localparam int LEN_S = (WORD_W < SHORT_W) ? WORD_W : SHORT_W;
    localparam logic [SLOT_W-1:0] FLD_L = SLOT_W'(FIELD_W);
    localparam logic [SLOT_W-1:0] FLD_S = SLOT_W'(SHORT_W);
    localparam logic [SLOT_W-1:0] ACT_L = SLOT_W'(LEN_L);
    localparam logic [SLOT_W-1:0] ACT_S = SLOT_W'(LEN_S);

    logic [WORD_W-1:0] lat_l;
    logic [WORD_W-1:0] lat_r;
    logic [WORD_W-1:0] word_now;
    logic [WORD_W-1:0] word_sh;
    logic [SLOT_W-1:0] fld_len;
    logic [SLOT_W-1:0] act_len;
    logic [SLOT_W-1:0] start;
    logic [SLOT_W-1:0] rel;
    logic              in_win;
    logic              frame_start;
    place_e            place;

    // Field length and the number of word bits that fit in it.
    always_comb begin
        fld_len = short_field ? FLD_S : FLD_L;
        act_len = short_field ? ACT_S : ACT_L;
    end

    // Slot that carries the MSB for the selected placement mode.
    always_comb begin
        place = place_e'(fmt);
        case (place)
            PLACE_RJUST: start = fld_len - act_len;
            PLACE_I2S:   start = SLOT_W'(1);
            default:     start = SLOT_W'(ofs);
        endcase
    end

    // Choose the word for this slot and test whether the slot lies in its window.
    always_comb begin
        frame_start = strobe && !chan && (slot == '0);
        if (frame_start)
            word_now = left_word;
        else
            word_now = chan ? lat_r : lat_l;
        rel     = slot - start;
        in_win  = (slot >= start) && (slot < fld_len) && (rel < act_len);
        word_sh = word_now << rel;
    end

    // Capture the word pair at the start of each left field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_l <= '0;
            lat_r <= '0;
        end else if (frame_start) begin
            lat_l <= left_word;
            lat_r <= right_word;
        end
    end

    // Update the data bit only at the bit-clock falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sdata <= 1'b0;
        else if (strobe)
            sdata <= in_win & word_sh[WORD_W-1];
    end

    // The data line may only move on a strobe.
    assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> $past(strobe));

    // The held left word changes only at the start of a frame.
    assert_hold_until_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lat_l) |-> $past(frame_start));

    // Slots past the end of the field are sent as zero.
    assert_zero_beyond_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && slot >= fld_len) |=> !sdata);

endmodule

// File: rtl/audio_serial_tx.sv
// Top of the stereo audio serial output port.
// Selects master or slave timing and feeds the chosen strobe, slot and channel
// to the formatter.
// The generated clocks go out only in master mode and are held low otherwise.
// Assumes: master_en, short_field, fmt and ofs are static pin selections.
module audio_serial_tx #(
    parameter int MCLK_PER_FS = 256,
    parameter int WORD_W      = 18,
    parameter int FIELD_W     = 32,
    parameter int SHORT_W     = 16,
    parameter int OFS_W       = $clog2(FIELD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              short_field,
    input  logic [1:0]        fmt,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [WORD_W-1:0] left_word,
    input  logic [WORD_W-1:0] right_word,
    input  logic              bclk_in,
    input  logic              wclk_in,
    output logic              bclk_out,
    output logic              wclk_out,
    output logic              sdata
);
    localparam int SLOT_W = OFS_W + 1;

    logic              m_bclk;
    logic              m_wclk;
    logic              m_strobe;
    logic              m_chan;
    logic [SLOT_W-1:0] m_slot;
    logic              s_strobe;
    logic              s_chan;
    logic [SLOT_W-1:0] s_slot;
    logic              t_strobe;
    logic              t_chan;
    logic [SLOT_W-1:0] t_slot;

    ast_master_timing #(
        .MCLK_PER_FS(MCLK_PER_FS),
        .FIELD_W    (FIELD_W),
        .SHORT_W    (SHORT_W),
        .SLOT_W     (SLOT_W)
    ) master_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .short_field(short_field),
        .bclk       (m_bclk),
        .wclk       (m_wclk),
        .strobe     (m_strobe),
        .nxt_chan   (m_chan),
        .nxt_slot   (m_slot)
    );

    ast_slave_timing #(
        .SLOT_W(SLOT_W)
    ) slave_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_in (bclk_in),
        .wclk_in (wclk_in),
        .strobe  (s_strobe),
        .nxt_chan(s_chan),
        .nxt_slot(s_slot)
    );

    // Route the selected timing source to the formatter.
    always_comb begin
        t_strobe = master_en ? m_strobe : s_strobe;
        t_chan   = master_en ? m_chan   : s_chan;
        t_slot   = master_en ? m_slot   : s_slot;
    end

    ast_formatter #(
        .WORD_W (WORD_W),
        .FIELD_W(FIELD_W),
        .SHORT_W(SHORT_W),
        .SLOT_W (SLOT_W),
        .OFS_W  (OFS_W)
    ) fmt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (t_strobe),
        .chan       (t_chan),
        .slot       (t_slot),
        .fmt        (fmt),
        .ofs        (ofs),
        .short_field(short_field),
        .left_word  (left_word),
        .right_word (right_word),
        .sdata      (sdata)
    );

    assign bclk_out = master_en & m_bclk;
    assign wclk_out = master_en & m_wclk;

    // In master mode the data line never moves while the bit clock stays high.
    assert_master_data_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && $past(master_en) && bclk_out && $past(bclk_out)) |-> $stable(sdata));

endmodule

// File: tb/audio_serial_tx_tb_top.sv
// Directed bench for the stereo audio serial output port.
module audio_serial_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b1;
    logic        short_field = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [4:0]  ofs = 5'd0;
    logic [17:0] left_word = '0;
    logic [17:0] right_word = '0;
    logic        bclk_in;
    logic        wclk_in;
    logic        bclk_out;
    logic        wclk_out;
    logic        sdata;
    logic        slave_on = 1'b0;
    int          sph = 0;
    int          sbit = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    audio_serial_tx dut_i (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .short_field(short_field),
        .fmt(fmt), .ofs(ofs), .left_word(left_word), .right_word(right_word),
        .bclk_in(bclk_in), .wclk_in(wclk_in), .bclk_out(bclk_out),
        .wclk_out(wclk_out), .sdata(sdata)
    );

    // External clock source for slave mode: 8 master clocks per bit, 64 bits per frame.
    always @(posedge clk) begin
        if (!slave_on) begin
            sph  <= 0;
            sbit <= 0;
        end else if (sph == 7) begin
            sph  <= 0;
            sbit <= (sbit == 63) ? 0 : sbit + 1;
        end else begin
            sph  <= sph + 1;
        end
    end
    assign bclk_in = slave_on && (sph >= 4);
    assign wclk_in = slave_on && (sbit >= 32);

    function automatic logic bk();
        return master_en ? bclk_out : bclk_in;
    endfunction

    function automatic logic wk();
        return master_en ? wclk_out : wclk_in;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Slot map of one channel field, built from the placement rules.
    function automatic logic [31:0] exp_field(input logic [17:0] w, input int fld, input int f, input int o);
        logic [31:0] r = '0;
        int len = (fld < 18) ? fld : 18;
        int st  = (f == 0) ? fld - len : (f == 1) ? 1 : o;
        for (int k = 0; k < fld; k++) begin
            int j = k - st;
            if (j >= 0 && j < len) r[k] = w[17 - j];
        end
        return r;
    endfunction

    // Record sdata and the word clock at each rising bit-clock edge of one frame.
    task automatic capture(input int nbits, input bit swap, input logic [17:0] nl, input logic [17:0] nr,
                           output logic [63:0] d, output logic [63:0] w);
        logic pw, pb;
        int idx = 0;
        d = '0;
        w = '0;
        pw = wk();
        @(negedge clk);
        while (!(pw && !wk())) begin
            pw = wk();
            @(negedge clk);
        end
        pb = bk();
        while (idx < nbits) begin
            @(negedge clk);
            if (!pb && bk()) begin
                d[idx] = sdata;
                w[idx] = wk();
                idx++;
                if (swap && idx == 8) begin
                    left_word  = nl;
                    right_word = nr;
                end
            end
            pb = bk();
        end
    endtask

    task automatic check_frame(input string req, input logic [17:0] l, input logic [17:0] r,
                               input int fld, input int f, input int o);
        logic [63:0] d, w, el, er, ew, al, ar;
        capture(2 * fld, 1'b0, '0, '0, d, w);
        capture(2 * fld, 1'b0, '0, '0, d, w);
        el = {32'd0, exp_field(l, fld, f, o)};
        er = {32'd0, exp_field(r, fld, f, o)};
        al = '0;
        ar = '0;
        ew = '0;
        for (int k = 0; k < fld; k++) begin
            al[k] = d[k];
            ar[k] = d[fld + k];
            ew[fld + k] = 1'b1;
        end
        chk(req, "left field", al, el);
        chk(req, "right field", ar, er);
        chk("R10", "word clock low for left, high for right", w, ew);
    endtask

    // Master cycles between two rises of the bit clock (sel=0) or two falls of the word clock (sel=1).
    task automatic period(input int sel, output int n);
        logic p, c;
        bit done = 0;
        p = sel ? ~wclk_out : bclk_out;
        @(negedge clk);
        c = sel ? ~wclk_out : bclk_out;
        while (!(!p && c)) begin
            p = c;
            @(negedge clk);
            c = sel ? ~wclk_out : bclk_out;
        end
        n = 0;
        p = c;
        while (!done) begin
            @(negedge clk);
            n++;
            c = sel ? ~wclk_out : bclk_out;
            if (!p && c) done = 1;
            p = c;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "sdata in reset", {63'd0, sdata}, 64'd0);
        chk("R1", "bclk_out in reset", {63'd0, bclk_out}, 64'd0);
        chk("R1", "wclk_out in reset", {63'd0, wclk_out}, 64'd0);
        @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        chk("R1", "outputs first cycle after reset", {61'd0, sdata, bclk_out, wclk_out}, 64'd0);
    endtask

    task automatic t_master_clocks();
        int n, hi;
        period(0, n);
        chk("R2", "bit clock period, 32-slot field", n, 4);
        period(1, n);
        chk("R2", "word clock period", n, 256);
        @(negedge clk);
        while (wclk_out) @(negedge clk);
        while (!wclk_out) @(negedge clk);
        hi = 0;
        while (wclk_out) begin
            hi++;
            @(negedge clk);
        end
        chk("R2", "word clock high time", hi, 128);
        short_field = 1'b1;
        repeat (600) @(negedge clk);
        period(0, n);
        chk("R2", "bit clock period, 16-slot field", n, 8);
        period(1, n);
        chk("R2", "word clock period, 16-slot field", n, 256);
        short_field = 1'b0;
        repeat (600) @(negedge clk);
    endtask

    task automatic t_edges();
        logic pb, pw, pd;
        int bad = 0;
        left_word  = 18'h2B6D9;
        right_word = 18'h1496D;
        fmt = 2'b01;
        pb = bclk_out; pw = wclk_out; pd = sdata;
        repeat (600) begin
            @(negedge clk);
            if ((wclk_out != pw || sdata != pd) && !(pb && !bclk_out)) bad++;
            pb = bclk_out; pw = wclk_out; pd = sdata;
        end
        chk("R3", "changes away from falling bit clock", bad, 0);
    endtask

    task automatic t_rjust();
        fmt = 2'b00; left_word = 18'h2A5C3; right_word = 18'h1F00F;
        check_frame("R4", 18'h2A5C3, 18'h1F00F, 32, 0, 0);
    endtask

    task automatic t_i2s();
        fmt = 2'b01; left_word = 18'h20001; right_word = 18'h15555;
        check_frame("R5", 18'h20001, 18'h15555, 32, 1, 0);
    endtask

    task automatic t_offset();
        fmt = 2'b10; ofs = 5'd3; left_word = 18'h3FFFF; right_word = 18'h0ABCD;
        check_frame("R6", 18'h3FFFF, 18'h0ABCD, 32, 2, 3);
        fmt = 2'b11; ofs = 5'd20; left_word = 18'h2D2D2; right_word = 18'h12345;
        check_frame("R6", 18'h2D2D2, 18'h12345, 32, 2, 20);
    endtask

    task automatic t_short();
        short_field = 1'b1;
        fmt = 2'b00; left_word = 18'h3C3A5; right_word = 18'h05A5A;
        check_frame("R7", 18'h3C3A5, 18'h05A5A, 16, 0, 0);
        fmt = 2'b01; left_word = 18'h3C3A7; right_word = 18'h05A5E;
        check_frame("R7", 18'h3C3A7, 18'h05A5E, 16, 1, 0);
        short_field = 1'b0;
    endtask

    task automatic t_latch();
        logic [63:0] d, w, al, ar;
        fmt = 2'b01; left_word = 18'h11111; right_word = 18'h22222;
        capture(64, 1'b0, '0, '0, d, w);
        capture(64, 1'b1, 18'h3AAAA, 18'h15555, d, w);
        al = '0; ar = '0;
        for (int k = 0; k < 32; k++) begin al[k] = d[k]; ar[k] = d[32 + k]; end
        chk("R8", "left held during mid-frame update", al, {32'd0, exp_field(18'h11111, 32, 1, 0)});
        chk("R8", "right held during mid-frame update", ar, {32'd0, exp_field(18'h22222, 32, 1, 0)});
        capture(64, 1'b0, '0, '0, d, w);
        al = '0;
        for (int k = 0; k < 32; k++) al[k] = d[k];
        chk("R8", "new left word in next frame", al, {32'd0, exp_field(18'h3AAAA, 32, 1, 0)});
    endtask

    task automatic t_slave();
        int hi = 0;
        slave_on = 1'b1;
        master_en = 1'b0;
        fmt = 2'b01; left_word = 18'h2F0F1; right_word = 18'h0C3C3;
        repeat (300) begin
            @(negedge clk);
            if (bclk_out || wclk_out) hi++;
        end
        chk("R9", "generated clocks held low in slave mode", hi, 0);
        check_frame("R9", 18'h2F0F1, 18'h0C3C3, 32, 1, 0);
        fmt = 2'b00;
        check_frame("R9", 18'h2F0F1, 18'h0C3C3, 32, 0, 0);
        master_en = 1'b1;
        slave_on = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_master_clocks();
        t_edges();
        t_rjust();
        t_i2s();
        t_offset();
        t_short();
        t_latch();
        t_slave();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule